// File: doc/BRIEF.md
# Cartridge Page Mapper

This block sits between an 8-bit CPU's 16-bit address bus and the memories of a game cartridge whose ROM is cut into 16 KB pages. It decodes three 16 KB CPU windows below 0xC000. The lowest window's first kilobyte is pinned to ROM page 0. Each window otherwise reads the ROM page held in its own page register. The top window can instead be given over to a 32 KB battery-backed cartridge RAM, split into two 16 KB halves. Accesses at 0xC000 and above go to the system work RAM, which repeats every 8 KB.

Software programs the mapper by writing to the last four bytes of the address space. Those writes also land in work RAM. Page registers can also be loaded through single alias addresses inside the cartridge windows, as some cartridge families expect. The registers keep the raw bytes that were written, and the page number is reduced to the ROM size only when an address is formed. A sticky flag records whether the save RAM has really changed. A second sticky flag records control writes with undefined bits set.

Top module: `cart_page_mapper`

## Requirements
- R1: After reset the read-back ports show control 0x00, window-0 page 0x00, window-1 page 0x01 and window-2 page 0x02. Both sticky flags are 0.
- R2: A read at 0x0000–0x03FF asserts `rom_cs` with `rom_addr` equal to the CPU address, whatever the window-0 page is.
- R3: A read at 0x0400–0x3FFF forms `rom_addr` from the window-0 page. A read at 0x4000–0x7FFF forms it from the window-1 page. In both cases the page is shifted left 14 bits and added to the low 14 address bits.
- R4: The page number used in `rom_addr` is the stored byte ANDed with ROM_PAGES−1. The read-back ports still return the unmasked byte.
- R5: Writes to 0xFFFC/0xFFFD/0xFFFE/0xFFFF load control/page 0/page 1/page 2 at the clock edge. Alias writes also load registers: 0x0000 loads page 0, 0x4000 loads page 1, and 0x8000 or 0xA000 load page 2.
- R6: With control bit 3 set, 0x8000–0xBFFF selects cartridge RAM (`cram_cs`, and `cram_we` on writes) at address {control bit 2, addr[13:0]}. In this state writes at 0x8000/0xA000 do not load page 2.
- R7: With control bit 3 clear, 0x8000–0xBFFF reads ROM through the page-2 register, and writes there never assert `cram_we`.
- R8: `cram_dirty` is set by a cartridge-RAM write whose data differs from `cram_rdata`. It stays set until reset. Writing an equal byte leaves it unchanged.
- R9: `ctrl_anomaly` is set by a control write with any bit outside 0x8C set, and stays set until reset. Writes using only bits 7, 3 and 2 do not set it.
- R10: Accesses at 0xC000 and above assert `sys_cs` (and `sys_we` on writes) with `sys_addr` = addr[12:0]. At most one of `rom_cs`, `cram_cs` and `sys_cs` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address |
| rd | input | 1 | CPU read strobe |
| wr | input | 1 | CPU write strobe |
| wdata | input | 8 | CPU write data |
| cram_rdata | input | 8 | Byte currently stored at `cram_addr` |
| rom_cs | output | 1 | ROM read select |
| rom_addr | output | PAGE_W+14 | ROM byte address |
| cram_cs | output | 1 | Cartridge RAM select |
| cram_we | output | 1 | Cartridge RAM write enable |
| cram_addr | output | 15 | Cartridge RAM byte address |
| sys_cs | output | 1 | Work RAM select |
| sys_we | output | 1 | Work RAM write enable |
| sys_addr | output | 13 | Work RAM address |
| reg_ctrl | output | 8 | Raw control register |
| reg_page0 | output | 8 | Raw window-0 page |
| reg_page1 | output | 8 | Raw window-1 page |
| reg_page2 | output | 8 | Raw window-2 page |
| cram_dirty | output | 1 | Save RAM changed |
| ctrl_anomaly | output | 1 | Undefined control bits were written |

## Verification
The assertions watch, on every cycle, that the pinned first kilobyte maps straight through, that the selects never overlap, that the RAM write enable only fires while RAM is mapped, and that both sticky flags hold and registers change only under a write. Only the bench scenarios can show the actual page arithmetic and the effect of masking on a raw byte. They also show that the alias writes are ignored while RAM is mapped, that a same-value RAM write leaves the dirty flag clear, and that reset restores the register values.

// File: rtl/cart_page_mapper.sv
module cart_page_mapper #(
  parameter int ROM_PAGES = 16,
  localparam int PAGE_W = (ROM_PAGES > 1) ? $clog2(ROM_PAGES) : 1,
  localparam int ROM_AW = PAGE_W + 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        cram_rdata,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              cram_cs,
  output logic              cram_we,
  output logic [14:0]       cram_addr,
  output logic              sys_cs,
  output logic              sys_we,
  output logic [12:0]       sys_addr,
  output logic [7:0]        reg_ctrl,
  output logic [7:0]        reg_page0,
  output logic [7:0]        reg_page1,
  output logic [7:0]        reg_page2,
  output logic              cram_dirty,
  output logic              ctrl_anomaly
);

  logic [PAGE_W-1:0] page;
  logic in_rom, in_cram, in_sys;
  logic reg_hit, alias0, alias1, alias2;

  always_comb begin
    page    = '0;
    in_rom  = 1'b0;
    in_cram = 1'b0;
    in_sys  = 1'b0;
    case (addr[15:14])
      2'd0: begin
        in_rom = 1'b1;
        page   = (addr[13:10] == 4'd0) ? '0 : reg_page0[PAGE_W-1:0];
      end
      2'd1: begin
        in_rom = 1'b1;
        page   = reg_page1[PAGE_W-1:0];
      end
      2'd2: begin
        in_cram = reg_ctrl[3];
        in_rom  = !reg_ctrl[3];
        page    = reg_page2[PAGE_W-1:0];
      end
      default: in_sys = 1'b1;
    endcase
  end

  assign rom_cs    = rd & in_rom;
  assign rom_addr  = {page, addr[13:0]};
  assign cram_cs   = (rd | wr) & in_cram;
  assign cram_we   = wr & in_cram;
  assign cram_addr = {reg_ctrl[2], addr[13:0]};
  assign sys_cs    = (rd | wr) & in_sys;
  assign sys_we    = wr & in_sys;
  assign sys_addr  = addr[12:0];

  assign reg_hit = wr && (addr[15:2] == 14'h3FFF);
  assign alias0  = wr && (addr == 16'h0000);
  assign alias1  = wr && (addr == 16'h4000);
  assign alias2  = wr && !reg_ctrl[3] && (addr == 16'h8000 || addr == 16'hA000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_ctrl     <= 8'h00;
      reg_page0    <= 8'h00;
      reg_page1    <= 8'h01;
      reg_page2    <= 8'h02;
      cram_dirty   <= 1'b0;
      ctrl_anomaly <= 1'b0;
    end else begin
      if (reg_hit) begin
        case (addr[1:0])
          2'd0: begin
            reg_ctrl <= wdata;
            if ((wdata & 8'h73) != 8'h00) ctrl_anomaly <= 1'b1;
          end
          2'd1: reg_page0 <= wdata;
          2'd2: reg_page1 <= wdata;
          default: reg_page2 <= wdata;
        endcase
      end
      if (alias0) reg_page0 <= wdata;
      if (alias1) reg_page1 <= wdata;
      if (alias2) reg_page2 <= wdata;
      if (cram_we && (wdata != cram_rdata)) cram_dirty <= 1'b1;
    end
  end

endmodule

module cart_page_mapper_chk #(
  parameter int ROM_AW = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       addr,
  input logic              rd,
  input logic              wr,
  input logic              rom_cs,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              cram_cs,
  input logic              cram_we,
  input logic              sys_cs,
  input logic [7:0]        reg_ctrl,
  input logic [7:0]        reg_page0,
  input logic [7:0]        reg_page1,
  input logic [7:0]        reg_page2,
  input logic              cram_dirty,
  input logic              ctrl_anomaly
);

  AST_LOW_KB_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr < 16'h0400) |-> (rom_cs && rom_addr == ROM_AW'(addr))); // R2

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, cram_cs, sys_cs})); // R10

  AST_CRAM_WE_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    cram_we |-> reg_ctrl[3]); // R7

  AST_DIRTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cram_dirty |=> cram_dirty); // R8

  AST_ANOMALY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_anomaly |=> ctrl_anomaly); // R9

  AST_REGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable({reg_ctrl, reg_page0, reg_page1, reg_page2})); // R5

endmodule

bind cart_page_mapper cart_page_mapper_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
  .rom_cs(rom_cs), .rom_addr(rom_addr), .cram_cs(cram_cs), .cram_we(cram_we),
  .sys_cs(sys_cs), .reg_ctrl(reg_ctrl), .reg_page0(reg_page0),
  .reg_page1(reg_page1), .reg_page2(reg_page2), .cram_dirty(cram_dirty),
  .ctrl_anomaly(ctrl_anomaly)
);

// File: tb/tb_cart_page_mapper.sv
module tb_cart_page_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_AW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] cram_rdata;
  logic rom_cs, cram_cs, cram_we, sys_cs, sys_we, cram_dirty, ctrl_anomaly;
  logic [ROM_AW-1:0] rom_addr;
  logic [14:0] cram_addr;
  logic [12:0] sys_addr;
  logic [7:0] reg_ctrl, reg_page0, reg_page1, reg_page2;

  logic [7:0] ram_model [int];

  typedef struct { string req; int probe; logic [31:0] exp; } item_t;
  item_t sb[$];
  event go;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  cart_page_mapper dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .cram_rdata(cram_rdata), .rom_cs(rom_cs), .rom_addr(rom_addr),
    .cram_cs(cram_cs), .cram_we(cram_we), .cram_addr(cram_addr),
    .sys_cs(sys_cs), .sys_we(sys_we), .sys_addr(sys_addr),
    .reg_ctrl(reg_ctrl), .reg_page0(reg_page0), .reg_page1(reg_page1),
    .reg_page2(reg_page2), .cram_dirty(cram_dirty), .ctrl_anomaly(ctrl_anomaly)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb cram_rdata = ram_model.exists(int'(cram_addr)) ? ram_model[int'(cram_addr)] : 8'h00;

  always @(posedge clk) if (cram_we) ram_model[int'(cram_addr)] = wdata;

  function automatic logic [31:0] observe(int p);
    case (p)
      1: return {29'd0, rom_cs, cram_cs, sys_cs};
      2: return 32'(rom_addr);
      3: return 32'(cram_addr);
      4: return {reg_ctrl, reg_page0, reg_page1, reg_page2};
      5: return {30'd0, ctrl_anomaly, cram_dirty};
      6: return {18'd0, sys_we, sys_addr};
      7: return {31'd0, cram_we};
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(go);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = observe(it.probe);
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s probe %0d: actual %h expected %h", it.req, it.probe, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, int probe, logic [31:0] exp);
    item_t it;
    it.req = req; it.probe = probe; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic flush();
    -> go;
    #2;
  endtask

  task automatic bus(logic [15:0] a, logic r, logic w, logic [7:0] d);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d;
  endtask

  task automatic write_reg(logic [15:0] a, logic [7:0] d);
    bus(a, 1'b0, 1'b1, d);
    bus(16'hC000, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    expect_val("R1", 4, 32'h0000_0102); expect_val("R1", 5, 0); flush();

    bus(16'h0123, 1, 0, 0);
    expect_val("R2", 1, 32'b100); expect_val("R2", 2, 32'h0123); flush();

    bus(16'hFFFD, 0, 1, 8'h03);
    expect_val("R10", 1, 32'b001); expect_val("R10", 6, {19'd1, 13'h1FFD}); flush();
    bus(16'h0123, 1, 0, 0); expect_val("R2", 2, 32'h0123); flush();
    bus(16'h03FF, 1, 0, 0); expect_val("R2", 2, 32'h03FF); flush();
    bus(16'h0400, 1, 0, 0); expect_val("R3", 2, 32'h0C400); flush();
    bus(16'h0500, 1, 0, 0); expect_val("R3", 2, 32'h0C500); flush();

    write_reg(16'hFFFE, 8'h05);
    bus(16'h4567, 1, 0, 0); expect_val("R3", 2, 32'h14567); flush();

    write_reg(16'hFFFF, 8'h13);
    expect_val("R4", 4, 32'h0003_0513); flush();
    bus(16'h8001, 1, 0, 0); expect_val("R4", 2, 32'h0C001); flush();

    write_reg(16'h0000, 8'h07);
    write_reg(16'h4000, 8'h09);
    write_reg(16'hA000, 8'h0B);
    expect_val("R5", 4, 32'h0007_090B); flush();
    write_reg(16'h8000, 8'h02);
    expect_val("R5", 4, 32'h0007_0902); flush();

    bus(16'h9000, 0, 1, 8'h77);
    expect_val("R7", 7, 0); expect_val("R7", 1, 32'b000); flush();
    bus(16'hC000, 0, 0, 0); expect_val("R7", 4, 32'h0007_0902); flush();

    write_reg(16'hFFFC, 8'h08);
    expect_val("R9", 5, 0); flush();
    bus(16'h8004, 1, 0, 0);
    expect_val("R6", 1, 32'b010); expect_val("R6", 3, 32'h0004); flush();
    write_reg(16'hFFFC, 8'h0C);
    bus(16'hBFFF, 1, 0, 0); expect_val("R6", 3, 32'h7FFF); flush();

    write_reg(16'h8010, 8'h00);
    expect_val("R8", 5, 0); flush();
    write_reg(16'h8010, 8'h5A);
    expect_val("R8", 5, 32'b01); flush();
    write_reg(16'h8010, 8'h5A);
    expect_val("R8", 5, 32'b01); flush();

    bus(16'hA000, 0, 1, 8'h44);
    expect_val("R6", 7, 1); flush();
    bus(16'hC000, 0, 0, 0); expect_val("R6", 4, 32'h0C07_0902); flush();

    write_reg(16'hFFFC, 8'h8C);
    expect_val("R9", 5, 32'b01); flush();
    write_reg(16'hFFFC, 8'h01);
    expect_val("R9", 5, 32'b11); expect_val("R4", 4, 32'h0107_0902); flush();
    bus(16'h8004, 1, 0, 0);
    expect_val("R7", 1, 32'b100); expect_val("R7", 2, 32'h08004); flush();

    bus(16'hC010, 1, 0, 0);
    expect_val("R10", 1, 32'b001); expect_val("R10", 6, {19'd0, 13'h0010}); flush();

    @(negedge clk); rst_n = 1'b0; rd = 0; wr = 0;
    @(negedge clk);
    expect_val("R1", 4, 32'h0000_0102); expect_val("R1", 5, 0); flush();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule